// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a synchronous DRAM from reset until the device is ready for ordinary traffic. It holds clock enable high and keeps the bus idle for a programmable settling time. It then closes every bank and runs two refresh cycles, each spaced by the refresh cycle time. Last, it writes a mode word built from configuration inputs. Once the mode-load lockout has run out, it raises a done flag, and the normal memory controller takes the bus from that point on.

Every delay is a clock-count parameter. The mode word is built from four configuration fields. Any field value the memory does not support is replaced with a safe value, and an error flag records that a replacement was made. A restart input can re-run the whole sequence at any time. The command on the bus is a 4-bit chip-select/row-strobe/column-strobe/write-enable pattern, all active low. Idle is `0111`.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and for the first WAIT_CYC cycles after the cycle in which reset is released, the bus carries idle (`{cs_n,ras_n,cas_n,we_n}=0111`) and `init_done_o` is low.
- R2: In cycle WAIT_CYC after release, the bus carries a close-all-banks command `0010` with address bit 10 high, all other address bits zero and bank bits zero.
- R3: TRP_CYC cycles after the close-all command, a refresh `0001` is issued. A second refresh follows TRFC_CYC cycles after the first. Address and bank are zero on both.
- R4: TRFC_CYC cycles after the second refresh, a mode load `0000` is issued with bank bits zero and the mode word on the address bus.
- R5: Mode word layout: A2:A0 hold the burst-length code, A3 the burst order (0 linear, 1 interleaved), A6:A4 the read latency and A9 the single-write flag. A8:A7, A11:A10 and any higher address bits are always zero.
- R6: A latency code other than 2 or 3 is sent as 3. `cfg_err_o` then goes high in the cycle after the mode load.
- R7: A burst-length code of 4, 5 or 6, or 7 together with interleaved order, is sent as 0 (length 1). `cfg_err_o` is then set in the same way. Code 7 with linear order (full row) is legal.
- R8: `cke_o` is high in every cycle. Every cycle not named in R2 to R4 carries idle.
- R9: `init_done_o` rises exactly TMRD_CYC cycles after the mode-load cycle and stays high, with idle on the bus, until reset or restart.
- R10: When `reinit_i` is sampled high, `init_done_o` and `cfg_err_o` are low in the next cycle. That cycle is cycle 0 of a new sequence timed as in R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit_i | input | 1 | Restart the sequence from the settling wait |
| cfg_burst_len_i | input | 3 | Burst-length code |
| cfg_burst_type_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| cfg_cas_lat_i | input | 3 | Read latency in clocks (2 or 3) |
| cfg_wr_single_i | input | 1 | 1: writes are single-location |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W | Address bus |
| ba_o | output | BANK_W | Bank select |
| init_done_o | output | 1 | Sequence complete, bus may be handed over |
| cfg_err_o | output | 1 | A configuration field was replaced |

## Verification
The bench compares every cycle of each sequence against an expected command timeline. An off-by-one dwell counter would therefore show up as a command one cycle early or late, and a missing idle gap would show up as a back-to-back command. Illegal latency codes and reserved burst codes, including full-row length combined with interleaved order, are applied. A faulty sanitizer would put an unsupported value on A6:A4 or A2:A0, or would leave the error flag low. A restart is applied both in the middle of a sequence and after completion, which exposes a done flag that lingers or a timer that does not reload. A done flag raised one cycle early would break the mode-load lockout and is caught by the exact cycle check.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    localparam int MODE_W = 12;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_LMR = 4'b0000
    } cmd_e;

    typedef enum logic [2:0] {
        PH_WAIT = 3'd0,
        PH_PRE  = 3'd1,
        PH_REF1 = 3'd2,
        PH_REF2 = 3'd3,
        PH_LMR  = 3'd4,
        PH_DONE = 3'd5
    } phase_e;

    typedef struct packed {
        logic [2:0] blen;
        logic       interleave;
        logic [2:0] lat;
        logic       wr_single;
    } mode_cfg_t;

    localparam logic [2:0] SAFE_BLEN = 3'd0;
    localparam logic [2:0] SAFE_LAT  = 3'd3;

    function automatic logic lat_ok(input logic [2:0] lat);
        return (lat == 3'd2) || (lat == 3'd3);
    endfunction

    function automatic logic blen_ok(input logic [2:0] blen, input logic interleave);
        return (blen <= 3'd3) || ((blen == 3'd7) && !interleave);
    endfunction

    function automatic logic [MODE_W-1:0] pack_mode(input mode_cfg_t c);
        logic [MODE_W-1:0] w;
        w       = '0;
        w[2:0]  = c.blen;
        w[3]    = c.interleave;
        w[6:4]  = c.lat;
        w[9]    = c.wr_single;
        return w;
    endfunction

endpackage

// File: rtl/boot_dwell_timer.sv
module boot_dwell_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/boot_mode_sanitizer.sv
module boot_mode_sanitizer
    import sdram_boot_pkg::*;
(
    input  mode_cfg_t cfg_in,
    output mode_cfg_t cfg_out,
    output logic      bad
);
    logic lat_bad, blen_bad;

    always_comb begin
        lat_bad  = !lat_ok(cfg_in.lat);
        blen_bad = !blen_ok(cfg_in.blen, cfg_in.interleave);
        cfg_out  = cfg_in;
        if (lat_bad)  cfg_out.lat  = SAFE_LAT;
        if (blen_bad) cfg_out.blen = SAFE_BLEN;
        bad = lat_bad | blen_bad;
    end
endmodule

// File: rtl/boot_cmd_encoder.sv
module boot_cmd_encoder
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2
) (
    input  phase_e            phase,
    input  logic              first,
    input  logic [MODE_W-1:0] mode_word,
    output cmd_e              cmd,
    output logic [ROW_W-1:0]  addr,
    output logic [BANK_W-1:0] bank
);
    localparam int ALL_BANKS_BIT = 10;

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        bank = '0;
        if (first) begin
            unique case (phase)
                PH_PRE: begin
                    cmd                 = CMD_PRE;
                    addr[ALL_BANKS_BIT] = 1'b1;
                end
                PH_REF1, PH_REF2: cmd = CMD_REF;
                PH_LMR: begin
                    cmd                = CMD_LMR;
                    addr[MODE_W-1:0]   = mode_word;
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/boot_phase_fsm.sv
module boot_phase_fsm
    import sdram_boot_pkg::*;
#(
    parameter int WAIT_CYC = 13300,
    parameter int TRP_CYC  = 3,
    parameter int TRFC_CYC = 10,
    parameter int TMRD_CYC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   reinit,
    output phase_e phase,
    output logic   first
);
    localparam int MAX_A  = (WAIT_CYC > TRFC_CYC) ? WAIT_CYC : TRFC_CYC;
    localparam int MAX_B  = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
    localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_D + 1);

    phase_e           phase_q, phase_d;
    logic             first_q;
    logic             expired, adv, load;
    logic [CNT_W-1:0] load_val;

    function automatic logic [CNT_W-1:0] dwell_m1(input phase_e p);
        case (p)
            PH_WAIT:          return CNT_W'(WAIT_CYC - 1);
            PH_PRE:           return CNT_W'(TRP_CYC - 1);
            PH_REF1, PH_REF2: return CNT_W'(TRFC_CYC - 1);
            PH_LMR:           return CNT_W'(TMRD_CYC - 1);
            default:          return '0;
        endcase
    endfunction

    assign adv = (phase_q != PH_DONE) && expired;

    always_comb begin
        phase_d = phase_q;
        if (reinit)
            phase_d = PH_WAIT;
        else if (adv)
            phase_d = phase_e'(phase_q + 3'd1);
    end

    assign load     = reinit | adv;
    assign load_val = dwell_m1(phase_d);

    boot_dwell_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (WAIT_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WAIT;
            first_q <= 1'b1;
        end else begin
            phase_q <= phase_d;
            first_q <= load;
        end
    end

    assign phase = phase_q;
    assign first = first_q;
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int BANK_W   = 2,
    parameter int WAIT_CYC = 13300,
    parameter int TRP_CYC  = 3,
    parameter int TRFC_CYC = 10,
    parameter int TMRD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reinit_i,
    input  logic [2:0]        cfg_burst_len_i,
    input  logic              cfg_burst_type_i,
    input  logic [2:0]        cfg_cas_lat_i,
    input  logic              cfg_wr_single_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [BANK_W-1:0] ba_o,
    output logic              init_done_o,
    output logic              cfg_err_o
);
    phase_e            phase;
    logic              first;
    mode_cfg_t         cfg_raw, cfg_safe;
    logic              cfg_bad;
    logic [MODE_W-1:0] mode_word;
    cmd_e              cmd;
    logic              err_q;

    assign cfg_raw = '{blen: cfg_burst_len_i, interleave: cfg_burst_type_i,
                       lat: cfg_cas_lat_i, wr_single: cfg_wr_single_i};

    boot_phase_fsm #(
        .WAIT_CYC (WAIT_CYC),
        .TRP_CYC  (TRP_CYC),
        .TRFC_CYC (TRFC_CYC),
        .TMRD_CYC (TMRD_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .reinit (reinit_i),
        .phase  (phase),
        .first  (first)
    );

    boot_mode_sanitizer u_sanitize (
        .cfg_in  (cfg_raw),
        .cfg_out (cfg_safe),
        .bad     (cfg_bad)
    );

    assign mode_word = pack_mode(cfg_safe);

    boot_cmd_encoder #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_enc (
        .phase     (phase),
        .first     (first),
        .mode_word (mode_word),
        .cmd       (cmd),
        .addr      (addr_o),
        .bank      (ba_o)
    );

    always_ff @(posedge clk) begin
        if (rst || reinit_i)
            err_q <= 1'b0;
        else if (phase == PH_LMR && first)
            err_q <= cfg_bad;
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
    assign cke_o       = 1'b1;
    assign init_done_o = (phase == PH_DONE);
    assign cfg_err_o   = err_q;
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
    parameter int ROW_W    = 12,
    parameter int TMRD_CYC = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             reinit_i,
    input logic             cke_o,
    input logic             cs_n_o,
    input logic             ras_n_o,
    input logic             cas_n_o,
    input logic             we_n_o,
    input logic [ROW_W-1:0] addr_o,
    input logic             init_done_o
);
    localparam int MW = $clog2(TMRD_CYC + 2) + 1;

    logic [3:0]    cmd;
    logic          is_nop, is_pre, is_lmr;
    logic [MW-1:0] since_lmr;

    assign cmd    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    assign is_nop = (cmd == 4'b0111);
    assign is_pre = (cmd == 4'b0010);
    assign is_lmr = (cmd == 4'b0000);

    always_ff @(posedge clk) begin
        if (rst)
            since_lmr <= '0;
        else if (is_lmr)
            since_lmr <= MW'(1);
        else if (since_lmr != '0 && since_lmr != MW'(TMRD_CYC + 1))
            since_lmr <= since_lmr + 1'b1;
    end

    assert_cke_high_R8: assert property (@(posedge clk) disable iff (rst)
        cke_o);

    assert_pre_all_banks_R2: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> addr_o[10]);

    assert_mode_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (addr_o[8:7] == 2'b00 && addr_o[11:10] == 2'b00));

    assert_mode_latency_legal_R6: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (addr_o[6:4] == 3'd2 || addr_o[6:4] == 3'd3));

    assert_mode_blen_legal_R7: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (addr_o[2:0] <= 3'd3 || (addr_o[2:0] == 3'd7 && !addr_o[3])));

    assert_done_after_lockout_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> (since_lmr == MW'(TMRD_CYC)));

    assert_done_bus_idle_R9: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> is_nop);

    assert_reinit_drops_done_R10: assert property (@(posedge clk) disable iff (rst)
        reinit_i |=> !init_done_o);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .ROW_W    (ROW_W),
    .TMRD_CYC (TMRD_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reinit_i    (reinit_i),
    .cke_o       (cke_o),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .addr_o      (addr_o),
    .init_done_o (init_done_o)
);

// File: tb/tb_sdram_boot_seq.sv
module tb_sdram_boot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 12;
    localparam int BANK_W = 2;
    localparam int W      = 6;
    localparam int TRP    = 3;
    localparam int TRFC   = 4;
    localparam int TMRD   = 2;
    localparam int PRE_AT  = W;
    localparam int REF1_AT = W + TRP;
    localparam int REF2_AT = W + TRP + TRFC;
    localparam int LMR_AT  = W + TRP + 2 * TRFC;
    localparam int DONE_AT = LMR_AT + TMRD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reinit = 1'b0;
    logic [2:0] bl = 3'd0;
    logic bt = 1'b0;
    logic [2:0] cl = 3'd2;
    logic ws = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done, err;
    logic [ROW_W-1:0] addr;
    logic [BANK_W-1:0] ba;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_boot_seq #(
        .ROW_W (ROW_W), .BANK_W (BANK_W), .WAIT_CYC (W),
        .TRP_CYC (TRP), .TRFC_CYC (TRFC), .TMRD_CYC (TMRD)
    ) dut (
        .clk (clk), .rst (rst), .reinit_i (reinit),
        .cfg_burst_len_i (bl), .cfg_burst_type_i (bt),
        .cfg_cas_lat_i (cl), .cfg_wr_single_i (ws),
        .cke_o (cke), .cs_n_o (cs_n), .ras_n_o (ras_n), .cas_n_o (cas_n),
        .we_n_o (we_n), .addr_o (addr), .ba_o (ba),
        .init_done_o (done), .cfg_err_o (err)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] bus();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic set_cfg(input logic [2:0] b, input logic t, input logic [2:0] c, input logic s);
        bl = b; bt = t; cl = c; ws = s;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus() == 4'b0111 && !done && cke, "R1 reset state", bus(), 4'b0111);
        rst = 1'b0;
    endtask

    // Caller is at the negedge of cycle 0; checks every cycle of one sequence.
    task automatic run_seq(input string tag, input logic [11:0] word, input logic exp_err);
        for (int k = 0; k <= DONE_AT + 3; k++) begin
            logic [3:0] ec;
            logic [ROW_W-1:0] ea;
            ec = 4'b0111;
            ea = '0;
            if (k == PRE_AT) begin ec = 4'b0010; ea[10] = 1'b1; end
            else if (k == REF1_AT || k == REF2_AT) ec = 4'b0001;
            else if (k == LMR_AT) begin ec = 4'b0000; ea = word; end
            if (k < W)
                chk(bus() == ec, "R1 idle wait", bus(), ec);
            else if (k == PRE_AT)
                chk(bus() == ec && addr == ea && ba == '0, "R2 close all", {bus(), addr}, {ec, ea});
            else if (k == REF1_AT || k == REF2_AT)
                chk(bus() == ec && addr == ea && ba == '0, "R3 refresh", {bus(), addr}, {ec, ea});
            else if (k == LMR_AT)
                chk(bus() == ec && addr == ea && ba == '0, {"R4 R5 mode load ", tag}, {bus(), addr}, {ec, ea});
            else
                chk(bus() == ec, "R8 idle gap", bus(), ec);
            chk(cke == 1'b1, "R8 cke", cke, 1);
            chk(done == (k >= DONE_AT), "R9 done timing", done, k >= DONE_AT);
            chk(err == ((k > LMR_AT) ? exp_err : 1'b0), {"R6 R7 cfg_err ", tag}, err, exp_err);
            @(negedge clk);
        end
    endtask

    task automatic test_linear_cl2();
        set_cfg(3'd2, 1'b0, 3'd2, 1'b0);
        do_reset();
        run_seq("R5 bl4 linear cl2", 12'h022, 1'b0);
    endtask

    task automatic test_interleave_cl3();
        set_cfg(3'd3, 1'b1, 3'd3, 1'b1);
        do_reset();
        run_seq("R5 bl8 interleave cl3 single-write", 12'h23B, 1'b0);
    endtask

    task automatic test_full_row();
        set_cfg(3'd7, 1'b0, 3'd3, 1'b0);
        do_reset();
        run_seq("R7 full row linear legal", 12'h037, 1'b0);
    endtask

    task automatic test_bad_latency();
        set_cfg(3'd1, 1'b0, 3'd5, 1'b0);
        do_reset();
        run_seq("R6 latency 5 replaced", 12'h031, 1'b1);
    endtask

    task automatic test_bad_blen();
        set_cfg(3'd7, 1'b1, 3'd2, 1'b0);
        do_reset();
        run_seq("R7 full row interleaved", 12'h028, 1'b1);
        set_cfg(3'd5, 1'b0, 3'd3, 1'b1);
        do_reset();
        run_seq("R7 code 5 replaced", 12'h230, 1'b1);
    endtask

    task automatic test_reinit_mid();
        set_cfg(3'd2, 1'b0, 3'd2, 1'b0);
        do_reset();
        repeat (REF1_AT + 1) @(negedge clk);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        chk(!done && bus() == 4'b0111, "R10 mid restart", {done, bus()}, 4'b0111);
        run_seq("R10 restarted", 12'h022, 1'b0);
    endtask

    task automatic test_reinit_after_done();
        set_cfg(3'd1, 1'b0, 3'd7, 1'b0);
        do_reset();
        run_seq("R6 before restart", 12'h031, 1'b1);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        chk(!done, "R10 done drops", done, 0);
        chk(!err, "R10 err clears", err, 0);
        set_cfg(3'd0, 1'b1, 3'd2, 1'b1);
        run_seq("R10 fresh config", 12'h228, 1'b0);
    endtask

    task automatic test_hold_done();
        for (int i = 0; i < 20; i++) begin
            chk(done && bus() == 4'b0111, "R9 hold idle", {done, bus()}, 5'h17);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_linear_cl2();
        test_hold_done();
        test_interleave_cl3();
        test_full_row();
        test_bad_latency();
        test_bad_blen();
        test_reinit_mid();
        test_reinit_after_done();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule